// File: doc/BRIEF.md
# Dual Event Counter Monitor

This block counts activity for performance analysis. It holds one free-running cycle counter and two event counters, each 32 bits wide. Each event counter watches one line of an incoming pulse vector, and an 8-bit selector code picks that line. All control state is packed into a single control word. That word holds a run enable, one-shot clear commands, a divide-by-64 mode for the cycle counter, per-counter interrupt enables, sticky overflow flags and the two selector codes.

Software reaches the block through a single-cycle register port with four indices: the control word, the cycle counter and the two event counters. Any counter can be preloaded directly. The usual way to raise an interrupt after N events is to preload a counter with 2^32 - N. When a counter rolls over from all ones to zero, its overflow flag sets. A single level interrupt stays high while any flag is set whose enable is also set. Software clears a flag by writing 1 to it.

Top module: `pmon_top`

## Requirements
- R1: After synchronous reset the control word reads 0x0FFFF000, meaning both selectors idle (0xFF) and everything else zero. All three counters read 0 and `irq` is low.
- R2: While control bit 0 (run enable) is 0, no counter advances, whatever the pulse inputs do.
- R3: Event counter 0 uses selector bits 19:12 and event counter 1 uses selector bits 27:20. A counter adds 1 on each enabled clock in which `evt_pulse[code]` is high. Code 0xFF, or any code that is not below the number of pulse lines, never counts.
- R4: The cycle counter adds 1 on every enabled clock while control bit 3 is 0. While bit 3 is 1 it adds 1 once per 64 enabled clocks, the first increment landing on the 64th clock after it is cleared.
- R5: Writing 1 to control bit 1 zeroes both event counters. Writing 1 to control bit 2 zeroes the cycle counter and its divide-by-64 prescaler. Both bits act on that write only and always read back 0.
- R6: A counter that increments from 0xFFFFFFFF wraps to 0 and sets its flag. The flag bits are 8 for event counter 0, 9 for event counter 1 and 10 for the cycle counter.
- R7: A control write with 1 in a flag bit clears that flag, and a 0 leaves it unchanged. If an overflow of the same counter occurs in the same cycle as the clearing write, the flag stays set.
- R8: `irq` is high exactly while some flag is set whose enable is also set. The enables are bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the cycle counter.
- R9: Control bits 7, 11 and 31:28 always read 0, whatever was written to them.
- R10: The register indices are 0 for control, 1 for the cycle counter, 2 for event counter 0 and 3 for event counter 1. A direct counter write takes priority over an increment in the same cycle and never sets a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register at `reg_addr` |
| reg_addr | input | 2 | Register index (0 control, 1 cycle, 2 event 0, 3 event 1) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the register at `reg_addr` |
| evt_pulse | input | NUM_SRC (16) | Event pulse lines, one count per high clock |
| irq | output | 1 | Level interrupt for enabled, set overflow flags |

## Verification
Two pairs of functions can land in the same clock. In the first, the write that clears a flag coincides with a new overflow of that counter. The bench provokes this by preloading event counter 0 with all ones and driving the selected pulse in the same cycle as a control write carrying 1 in bit 8. It then reads back that the flag and `irq` stay set while the counter reads 0. In the second, a direct counter write meets a selected pulse. The write value must appear unchanged, with no flag set.

// File: rtl/pmon_pkg.sv
package pmon_pkg;

    localparam int REG_W       = 32;
    localparam int SEL_W       = 8;
    localparam int NUM_EVT_CNT = 2;
    localparam int NUM_FLAGS   = NUM_EVT_CNT + 1;
    localparam int FLAG_CYC    = NUM_EVT_CNT;

    localparam logic [SEL_W-1:0] SEL_IDLE = 8'hFF;

    // control word bit positions
    localparam int B_EN      = 0;
    localparam int B_EVT_RST = 1;
    localparam int B_CYC_RST = 2;
    localparam int B_DIV     = 3;
    localparam int B_IE_LO   = 4;
    localparam int B_RSVD_A  = B_IE_LO + NUM_FLAGS;
    localparam int B_OVF_LO  = 8;
    localparam int B_RSVD_B  = B_OVF_LO + NUM_FLAGS;
    localparam int B_SEL_LO  = 12;
    localparam int B_SEL_HI  = B_SEL_LO + NUM_EVT_CNT * SEL_W - 1;

    typedef enum logic [1:0] {
        IDX_CTRL = 2'd0,
        IDX_CYC  = 2'd1,
        IDX_EVT0 = 2'd2,
        IDX_EVT1 = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic [NUM_EVT_CNT-1:0][SEL_W-1:0] sel;
        logic [NUM_FLAGS-1:0]              ovf;
        logic [NUM_FLAGS-1:0]              ie;
        logic                              div;
        logic                              en;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        sel: {NUM_EVT_CNT{SEL_IDLE}},
        ovf: '0,
        ie:  '0,
        div: 1'b0,
        en:  1'b0
    };

    // build the readable image of the control word; one-shot and reserved bits read 0
    function automatic logic [REG_W-1:0] ctrl_pack(input ctrl_t c);
        logic [REG_W-1:0] r;
        r = '0;
        r[B_EN]                  = c.en;
        r[B_DIV]                 = c.div;
        r[B_IE_LO +: NUM_FLAGS]  = c.ie;
        r[B_OVF_LO +: NUM_FLAGS] = c.ovf;
        for (int k = 0; k < NUM_EVT_CNT; k++) begin
            r[B_SEL_LO + k*SEL_W +: SEL_W] = c.sel[k];
        end
        return r;
    endfunction

    function automatic logic [1:0] evt_index(input int k);
        return 2'(int'(IDX_EVT0) + k);
    endfunction

endpackage

// File: rtl/pmon_ctrl_reg.sv
module pmon_ctrl_reg
    import pmon_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  logic [REG_W-1:0]      wdata,
    input  logic [NUM_FLAGS-1:0]  ovf_set,
    output ctrl_t                 ctrl_q,
    output logic                  evt_clr,
    output logic                  cyc_clr
);

    logic [NUM_FLAGS-1:0] w1c;
    logic                 unused_rsvd;

    assign w1c     = wr ? wdata[B_OVF_LO +: NUM_FLAGS] : '0;
    assign evt_clr = wr & wdata[B_EVT_RST];
    assign cyc_clr = wr & wdata[B_CYC_RST];

    // reserved bits are accepted and dropped
    assign unused_rsvd = ^{wdata[B_RSVD_A], wdata[B_RSVD_B], wdata[REG_W-1:B_SEL_HI+1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
        end else begin
            if (wr) begin
                ctrl_q.en  <= wdata[B_EN];
                ctrl_q.div <= wdata[B_DIV];
                ctrl_q.ie  <= wdata[B_IE_LO +: NUM_FLAGS];
                for (int k = 0; k < NUM_EVT_CNT; k++) begin
                    ctrl_q.sel[k] <= wdata[B_SEL_LO + k*SEL_W +: SEL_W];
                end
            end
            // a fresh overflow outranks a clearing write
            ctrl_q.ovf <= (ctrl_q.ovf & ~w1c) | ovf_set;
        end
    end

endmodule

// File: rtl/pmon_event_counter.sv
module pmon_event_counter
    import pmon_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NUM_SRC = 16
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_SRC-1:0] src,
    input  logic               clr,
    input  logic               wr,
    input  logic [CNT_W-1:0]   wdata,
    output logic [CNT_W-1:0]   value,
    output logic               wrap
);

    logic hit;
    logic inc;

    always_comb begin
        hit = 1'b0;
        if (sel != SEL_IDLE) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (sel == SEL_W'(i)) hit = src[i];
            end
        end
    end

    assign inc  = en & hit;
    assign wrap = inc & (&value) & ~wr & ~clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (wr) begin
            value <= wdata;
        end else if (clr) begin
            value <= '0;
        end else if (inc) begin
            value <= value + 1'b1;
        end
    end

endmodule

// File: rtl/pmon_cycle_counter.sv
module pmon_cycle_counter
    import pmon_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PS_W  = 6
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             div,
    input  logic             clr,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] value,
    output logic             wrap
);

    logic [PS_W-1:0] ps;
    logic            tick;

    assign tick = en & (~div | (&ps));
    assign wrap = tick & (&value) & ~wr & ~clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ps <= '0;
        end else if (en && div) begin
            ps <= ps + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (wr) begin
            value <= wdata;
        end else if (clr) begin
            value <= '0;
        end else if (tick) begin
            value <= value + 1'b1;
        end
    end

endmodule

// File: rtl/pmon_top.sv
module pmon_top
    import pmon_pkg::*;
#(
    parameter int CNT_W         = 32,
    parameter int NUM_SRC       = 16,
    parameter int PRESCALE_LOG2 = 6
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [NUM_SRC-1:0] evt_pulse,
    output logic               irq
);

    ctrl_t                ctrl_q;
    logic                 ctrl_wr;
    logic                 evt_clr;
    logic                 cyc_clr;
    logic [NUM_FLAGS-1:0] ovf_set;
    logic [CNT_W-1:0]     cyc_val;
    logic [CNT_W-1:0]     evt_val [NUM_EVT_CNT];

    // plain views of control state, also used by the bound checker
    logic                 run_en;
    logic                 cyc_div;
    logic [NUM_FLAGS-1:0] ovf_flags;

    assign run_en    = ctrl_q.en;
    assign cyc_div   = ctrl_q.div;
    assign ovf_flags = ctrl_q.ovf;

    assign ctrl_wr = reg_wr && (reg_addr == IDX_CTRL);

    pmon_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr      (ctrl_wr),
        .wdata   (reg_wdata),
        .ovf_set (ovf_set),
        .ctrl_q  (ctrl_q),
        .evt_clr (evt_clr),
        .cyc_clr (cyc_clr)
    );

    pmon_cycle_counter #(
        .CNT_W (CNT_W),
        .PS_W  (PRESCALE_LOG2)
    ) u_cyc (
        .clk   (clk),
        .rst   (rst),
        .en    (ctrl_q.en),
        .div   (ctrl_q.div),
        .clr   (cyc_clr),
        .wr    (reg_wr && (reg_addr == IDX_CYC)),
        .wdata (reg_wdata[CNT_W-1:0]),
        .value (cyc_val),
        .wrap  (ovf_set[FLAG_CYC])
    );

    for (genvar g = 0; g < NUM_EVT_CNT; g++) begin : g_evt
        pmon_event_counter #(
            .CNT_W   (CNT_W),
            .NUM_SRC (NUM_SRC)
        ) u_evt (
            .clk   (clk),
            .rst   (rst),
            .en    (ctrl_q.en),
            .sel   (ctrl_q.sel[g]),
            .src   (evt_pulse),
            .clr   (evt_clr),
            .wr    (reg_wr && (reg_addr == evt_index(g))),
            .wdata (reg_wdata[CNT_W-1:0]),
            .value (evt_val[g]),
            .wrap  (ovf_set[g])
        );
    end

    always_comb begin
        case (reg_idx_e'(reg_addr))
            IDX_CTRL: reg_rdata = ctrl_pack(ctrl_q);
            IDX_CYC:  reg_rdata = REG_W'(cyc_val);
            IDX_EVT0: reg_rdata = REG_W'(evt_val[0]);
            default:  reg_rdata = REG_W'(evt_val[1]);
        endcase
    end

    assign irq = |(ctrl_q.ovf & ctrl_q.ie);

endmodule

// File: rtl/pmon_checker.sv
module pmon_checker
    import pmon_pkg::*;
#(
    parameter int CNT_W = 32
)(
    input logic                 clk,
    input logic                 rst,
    input logic                 reg_wr,
    input logic [1:0]           reg_addr,
    input logic [REG_W-1:0]     reg_wdata,
    input logic [REG_W-1:0]     reg_rdata,
    input logic                 irq,
    input logic                 run_en,
    input logic                 cyc_div,
    input logic [NUM_FLAGS-1:0] ovf_flags,
    input logic [CNT_W-1:0]     cyc_val,
    input logic [CNT_W-1:0]     evt0_val,
    input logic [CNT_W-1:0]     evt1_val
);

    assert_frozen_when_off_R2: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !reg_wr) |=> ($stable(cyc_val) && $stable(evt0_val) && $stable(evt1_val)));

    assert_cyc_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0 && reg_wdata[B_CYC_RST]) |=> (cyc_val == '0));

    assert_evt_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0 && reg_wdata[B_EVT_RST]) |=> (evt0_val == '0 && evt1_val == '0));

    assert_cyc_wrap_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (run_en && !cyc_div && (&cyc_val) && !reg_wr) |=> ovf_flags[FLAG_CYC]);

    assert_flag_sticky_evt0_R7: assert property (@(posedge clk) disable iff (rst)
        (ovf_flags[0] && !(reg_wr && reg_addr == 2'd0 && reg_wdata[B_OVF_LO])) |=> ovf_flags[0]);

    assert_flag_sticky_cyc_R7: assert property (@(posedge clk) disable iff (rst)
        (ovf_flags[FLAG_CYC] && !(reg_wr && reg_addr == 2'd0 && reg_wdata[B_OVF_LO + FLAG_CYC]))
        |=> ovf_flags[FLAG_CYC]);

    assert_irq_has_source_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ovf_flags != '0));

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd0) |-> (reg_rdata[B_RSVD_A] == 1'b0 && reg_rdata[B_RSVD_B] == 1'b0
                                && reg_rdata[REG_W-1:B_SEL_HI+1] == '0));

    assert_direct_write_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd2) |=> (evt0_val == $past(reg_wdata[CNT_W-1:0])));

endmodule

bind pmon_top pmon_checker #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .run_en    (run_en),
    .cyc_div   (cyc_div),
    .ovf_flags (ovf_flags),
    .cyc_val   (cyc_val),
    .evt0_val  (evt_val[0]),
    .evt1_val  (evt_val[1])
);

// File: tb/pmon_top_tb_top.sv
module pmon_top_tb_top;

    localparam int NSRC = 16;
    localparam int WATCHDOG_CYCLES = 100000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            reg_wr = 1'b0;
    logic [1:0]      reg_addr = 2'd0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NSRC-1:0] evt_pulse = '0;
    logic            irq;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pmon_top #(.CNT_W(32), .NUM_SRC(NSRC), .PRESCALE_LOG2(6)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_pulse (evt_pulse),
        .irq       (irq)
    );

    // control word image: en, div, ie[2:0], flags w1c[2:0], sel0, sel1, evt reset, cyc reset
    function automatic logic [31:0] mk(bit en, bit dv, logic [2:0] ie, logic [2:0] w1c,
                                       logic [7:0] s0, logic [7:0] s1, bit er, bit cr);
        return {4'h0, s1, s0, 1'b0, w1c, 1'b0, ie, dv, cr, er, en};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] idx, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = idx; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] idx, output logic [31:0] data);
        reg_addr = idx;
        #1;
        data = reg_rdata;
    endtask

    task automatic pulse(input logic [NSRC-1:0] p, input int n);
        for (int i = 0; i < n; i++) begin
            evt_pulse = p;
            @(negedge clk);
        end
        evt_pulse = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd_reg(2'd0, v); chk("R1 ctrl reset", v, 32'h0FFFF000);
        rd_reg(2'd1, v); chk("R1 cycle reset", v, 0);
        rd_reg(2'd2, v); chk("R1 evt0 reset", v, 0);
        rd_reg(2'd3, v); chk("R1 evt1 reset", v, 0);
        chk("R1 irq reset", {31'd0, irq}, 0);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        wr_reg(2'd0, mk(0, 0, 3'b000, 3'b000, 8'd2, 8'd3, 0, 0));
        pulse('1, 10);
        rd_reg(2'd1, v); chk("R2 cycle frozen", v, 0);
        rd_reg(2'd2, v); chk("R2 evt0 frozen", v, 0);
        rd_reg(2'd3, v); chk("R2 evt1 frozen", v, 0);
    endtask

    task automatic t_event_count();
        logic [31:0] v;
        wr_reg(2'd0, mk(1, 0, 3'b000, 3'b000, 8'd2, 8'd5, 1, 0));
        pulse(16'h0004, 3);
        pulse(16'h0024, 2);
        pulse(16'h0020, 1);
        rd_reg(2'd2, v); chk("R3 evt0 counts line 2", v, 5);
        rd_reg(2'd3, v); chk("R3 evt1 counts line 5", v, 3);
        // out-of-range code on counter 0, idle code on counter 1
        wr_reg(2'd0, mk(1, 0, 3'b000, 3'b000, 8'd20, 8'hFF, 0, 0));
        pulse('1, 4);
        rd_reg(2'd2, v); chk("R3 out-of-range code holds", v, 5);
        rd_reg(2'd3, v); chk("R3 idle code holds", v, 3);
    endtask

    task automatic t_evt_reset();
        logic [31:0] v;
        wr_reg(2'd0, mk(1, 0, 3'b000, 3'b000, 8'd2, 8'hFF, 1, 0));
        rd_reg(2'd2, v); chk("R5 evt0 cleared", v, 0);
        rd_reg(2'd3, v); chk("R5 evt1 cleared", v, 0);
        rd_reg(2'd0, v); chk("R5 reset bits read 0", v, mk(1, 0, 3'b000, 3'b000, 8'd2, 8'hFF, 0, 0));
    endtask

    task automatic t_cycle();
        logic [31:0] v;
        wr_reg(2'd0, mk(1, 0, 3'b000, 3'b000, 8'hFF, 8'hFF, 0, 1));
        repeat (10) @(negedge clk);
        rd_reg(2'd1, v); chk("R4 cycle every clock", v, 10);
        wr_reg(2'd0, mk(1, 1, 3'b000, 3'b000, 8'hFF, 8'hFF, 0, 1));
        rd_reg(2'd1, v); chk("R5 cycle cleared", v, 0);
        rd_reg(2'd0, v); chk("R5 cycle reset bit reads 0", v, mk(1, 1, 3'b000, 3'b000, 8'hFF, 8'hFF, 0, 0));
        repeat (63) @(negedge clk);
        rd_reg(2'd1, v); chk("R4 divided after 63", v, 0);
        @(negedge clk);
        rd_reg(2'd1, v); chk("R4 divided after 64", v, 1);
        repeat (64) @(negedge clk);
        rd_reg(2'd1, v); chk("R4 divided after 128", v, 2);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        wr_reg(2'd0, mk(0, 0, 3'b000, 3'b111, 8'hFF, 8'hFF, 0, 0));
        wr_reg(2'd2, 32'hFFFFFFFE);
        wr_reg(2'd0, mk(1, 0, 3'b001, 3'b000, 8'd2, 8'hFF, 0, 0));
        pulse(16'h0004, 1);
        rd_reg(2'd2, v); chk("R6 evt0 at all ones", v, 32'hFFFFFFFF);
        rd_reg(2'd0, v); chk("R6 no flag before wrap", {31'd0, v[8]}, 0);
        chk("R8 irq low before wrap", {31'd0, irq}, 0);
        pulse(16'h0004, 1);
        rd_reg(2'd2, v); chk("R6 evt0 wrapped", v, 0);
        rd_reg(2'd0, v); chk("R6 evt0 flag bit 8", {31'd0, v[8]}, 1);
        chk("R8 irq on enabled flag", {31'd0, irq}, 1);
        wr_reg(2'd0, mk(1, 0, 3'b001, 3'b001, 8'd2, 8'hFF, 0, 0));
        rd_reg(2'd0, v); chk("R7 flag cleared by 1", {31'd0, v[8]}, 0);
        chk("R8 irq drops", {31'd0, irq}, 0);
        // cycle counter wrap with its enable off
        wr_reg(2'd0, mk(0, 0, 3'b001, 3'b000, 8'd2, 8'hFF, 0, 0));
        wr_reg(2'd1, 32'hFFFFFFFE);
        wr_reg(2'd0, mk(1, 0, 3'b001, 3'b000, 8'd2, 8'hFF, 0, 0));
        repeat (2) @(negedge clk);
        rd_reg(2'd0, v); chk("R6 cycle flag bit 10", {31'd0, v[10]}, 1);
        chk("R8 masked flag keeps irq low", {31'd0, irq}, 0);
        wr_reg(2'd0, mk(1, 0, 3'b101, 3'b000, 8'd2, 8'hFF, 0, 0));
        rd_reg(2'd0, v); chk("R7 writing 0 keeps flag", {31'd0, v[10]}, 1);
        chk("R8 irq after enabling bit 6", {31'd0, irq}, 1);
        wr_reg(2'd0, mk(1, 0, 3'b101, 3'b100, 8'd2, 8'hFF, 0, 0));
        chk("R7 cycle flag clear drops irq", {31'd0, irq}, 0);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        wr_reg(2'd0, mk(1, 0, 3'b001, 3'b000, 8'd2, 8'hFF, 0, 0));
        wr_reg(2'd2, 32'hFFFFFFFF);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0;
        reg_wdata = mk(1, 0, 3'b001, 3'b001, 8'd2, 8'hFF, 0, 0);
        evt_pulse = 16'h0004;
        @(negedge clk);
        reg_wr = 1'b0; evt_pulse = '0;
        rd_reg(2'd0, v); chk("R7 overflow beats clear", {31'd0, v[8]}, 1);
        chk("R7 irq stays with surviving flag", {31'd0, irq}, 1);
        rd_reg(2'd2, v); chk("R6 evt0 wrapped in collision", v, 0);
        wr_reg(2'd0, mk(1, 0, 3'b001, 3'b001, 8'd2, 8'hFF, 0, 0));
        rd_reg(2'd0, v); chk("R7 later clear works", {31'd0, v[8]}, 0);
        // direct write against a selected pulse
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h00000100;
        evt_pulse = 16'h0004;
        @(negedge clk);
        reg_wr = 1'b0; evt_pulse = '0;
        rd_reg(2'd2, v); chk("R10 write beats increment", v, 32'h00000100);
        wr_reg(2'd2, 32'hFFFFFFFF);
        rd_reg(2'd0, v); chk("R10 direct write sets no flag", {31'd0, v[8]}, 0);
        wr_reg(2'd3, 32'h0000ABCD);
        rd_reg(2'd3, v); chk("R10 index 3 is evt1", v, 32'h0000ABCD);
        rd_reg(2'd2, v); chk("R10 index 2 unchanged", v, 32'hFFFFFFFF);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        wr_reg(2'd0, 32'hFFFFFF80);
        rd_reg(2'd0, v); chk("R9 reserved bits read 0", v, 32'h0FFFF000);
        chk("R9 irq low after reserved write", {31'd0, irq}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_disabled();
        t_event_count();
        t_evt_reset();
        t_cycle();
        t_wrap();
        t_collision();
        t_reserved();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule